// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Arbiter

This block is the per-processor end of an interrupt controller. The source logic sends it raise strobes, each tagged with a source index. For every source it also supplies a 4-bit priority, a vector, an activity flag, a sense type (level or edge) and a routing word. The arbiter keeps two sets over all sources: the raised set, for sources waiting to be taken, and the servicing set, for sources the processor has accepted. It also holds a task priority that screens out low-priority raises. It drives one of two interrupt lines towards the processor: the normal line, or the critical line for sources routed as critical to this processor.

The processor reaches the block through a small register port. Reading the acknowledge register takes the best raised source. The read returns that source's vector, or a spurious vector if the source is no longer valid. Writing the end-of-interrupt register retires the best servicing entry and may signal the processor again. On acknowledge, the block asks the source logic to clear a source's activity and its pending flag through two strobes.

Top module: `iack_arbiter`

## Requirements
- R1: After reset the task priority is 15, the spurious vector is all ones within VEC_W bits (0xFF by default), both sets are empty and both interrupt lines are low.
- R2: A raise whose source priority is not strictly greater than the task priority leaves the raised set unchanged and does not move either line.
- R3: An accepted raise sets the source's raised bit. The line goes high on the next cycle unless the source's priority is below that of the current raised winner. In that case the bit is still set and the lines keep their value.
- R4: When crit_en is high and bit CRIT_BASE-CPU_ID (bit 2 by default) of the source's routing word is set, the critical line is driven in place of the normal line.
- R5: The winner of a set is the member with the highest priority. On equal priority the lowest source index wins.
- R6: A read of the acknowledge register (address 2) makes both lines low on the next cycle and removes the winner from the raised set. With an empty raised set the read returns the spurious vector.
- R7: If the acknowledge winner's activity flag is clear, or its priority no longer exceeds the task priority, the read returns the spurious vector and pulses act_clr_vld for it. Otherwise the winner joins the servicing set and its vector is returned.
- R8: Acknowledging an edge-sensitive source (level flag 0) pulses both act_clr_vld and pend_clr_vld, with act_clr_idx naming the source.
- R9: A write to the end-of-interrupt register (address 3) removes the servicing winner. On the next cycle a line is raised, chosen by the raised winner's routing, if a raised winner exists and either nothing remains in servicing or its priority exceeds the priority of the remaining servicing winner.
- R10: A write to the task priority register (address 0) keeps the low 4 bits of the data, and a read returns the stored value.
- R11: The identity register (address 1) reads CPU_ID and ignores writes. The spurious vector register (address 4) is written masked to VEC_W bits. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_vld | input | 1 | Raise strobe from the source logic |
| raise_idx | input | IW | Index of the raised source |
| src_prio | input | NSRC*PW | Per-source priority, packed |
| src_vec | input | NSRC*VEC_W | Per-source vector, packed |
| src_active | input | NSRC | Per-source activity flag |
| src_level | input | NSRC | 1 = level-sensitive, 0 = edge-sensitive |
| src_route | input | NSRC*ROUTE_W | Per-source routing word, packed |
| crit_en | input | 1 | Enables critical-line routing |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of reg_rd |
| irq_o | output | 1 | Normal interrupt line |
| crit_o | output | 1 | Critical interrupt line |
| act_clr_vld | output | 1 | Request to clear a source's activity |
| act_clr_idx | output | IW | Source named by the clear requests |
| pend_clr_vld | output | 1 | Request to clear an edge source's pending flag |

## Verification
The assertions assume that a read and a write never come in the same cycle, that a raise does not coincide with an acknowledge or end-of-interrupt access, and that the source logic sets a source's activity flag before or together with its raise strobe. The stimulus issues one operation per cycle, sets the flag in the same cycle as the raise, and clears it one cycle after the block asks for it. Tie priorities, task-priority changes between raise and acknowledge, and inactive winners are reached by direct sequences.

// File: rtl/iack_pkg.sv
package iack_pkg;
  typedef enum logic [2:0] {
    REG_TASKPRI = 3'd0,
    REG_WHOAMI  = 3'd1,
    REG_ACK     = 3'd2,
    REG_EOI     = 3'd3,
    REG_SPUR    = 3'd4
  } iack_reg_e;
endpackage

// File: rtl/iack_pick.sv
module iack_pick #(
  parameter int N  = 8,
  parameter int PW = 4,
  parameter int IW = 3
) (
  input  logic [N-1:0]    sel,
  input  logic [N*PW-1:0] prio,
  output logic            found,
  output logic [IW-1:0]   idx,
  output logic [PW-1:0]   best
);
  // strict compare while scanning upward keeps the lowest index on ties
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (sel[i] && (!found || prio[i*PW +: PW] > best)) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/iack_line.sv
module iack_line (
  input  logic clk,
  input  logic rst_n,
  input  logic lower,
  input  logic set,
  input  logic set_crit,
  output logic irq_o,
  output logic crit_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o  <= 1'b0;
      crit_o <= 1'b0;
    end else begin
      if (lower) begin
        irq_o  <= 1'b0;
        crit_o <= 1'b0;
      end
      if (set) begin
        if (set_crit) crit_o <= 1'b1;
        else          irq_o  <= 1'b1;
      end
    end
  end

  // R6
  ack_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lower && !set |=> !irq_o && !crit_o);
  // R4
  line_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set && set_crit && !lower && !$past(crit_o) |=> crit_o && $stable(irq_o));
endmodule

// File: rtl/iack_arbiter.sv
module iack_arbiter #(
  parameter int NSRC      = 8,
  parameter int PW        = 4,
  parameter int VEC_W     = 8,
  parameter int ROUTE_W   = 4,
  parameter int CPU_ID    = 1,
  parameter int CRIT_BASE = 3,
  localparam int IW       = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     raise_vld,
  input  logic [IW-1:0]            raise_idx,
  input  logic [NSRC*PW-1:0]       src_prio,
  input  logic [NSRC*VEC_W-1:0]    src_vec,
  input  logic [NSRC-1:0]          src_active,
  input  logic [NSRC-1:0]          src_level,
  input  logic [NSRC*ROUTE_W-1:0]  src_route,
  input  logic                     crit_en,
  input  logic                     reg_rd,
  input  logic                     reg_wr,
  input  logic [2:0]               reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  output logic                     irq_o,
  output logic                     crit_o,
  output logic                     act_clr_vld,
  output logic [IW-1:0]            act_clr_idx,
  output logic                     pend_clr_vld
);
  import iack_pkg::*;

  localparam int CRIT_BIT = CRIT_BASE - CPU_ID;

  function automatic logic [PW-1:0] prio_of(input logic [IW-1:0] i);
    return src_prio[i*PW +: PW];
  endfunction

  function automatic logic crit_of(input logic [IW-1:0] i);
    return crit_en && src_route[i*ROUTE_W + CRIT_BIT];
  endfunction

  function automatic logic [NSRC-1:0] bit_of(input logic [IW-1:0] i);
    return {{(NSRC-1){1'b0}}, 1'b1} << i;
  endfunction

  logic [NSRC-1:0]  raised_q, serv_q, raised_nxt, serv_nxt, serv_rest;
  logic [PW-1:0]    tpri_q;
  logic [VEC_W-1:0] spur_q;

  logic            r_found, s_found, rest_found;
  logic [IW-1:0]   r_idx, s_idx, rest_idx;
  logic [PW-1:0]   r_prio, s_prio, rest_prio;

  iack_pick #(.N(NSRC), .PW(PW), .IW(IW)) u_pick_raised (
    .sel(raised_q), .prio(src_prio), .found(r_found), .idx(r_idx), .best(r_prio));
  iack_pick #(.N(NSRC), .PW(PW), .IW(IW)) u_pick_serv (
    .sel(serv_q), .prio(src_prio), .found(s_found), .idx(s_idx), .best(s_prio));
  assign serv_rest = s_found ? (serv_q & ~bit_of(s_idx)) : serv_q;
  iack_pick #(.N(NSRC), .PW(PW), .IW(IW)) u_pick_rest (
    .sel(serv_rest), .prio(src_prio), .found(rest_found), .idx(rest_idx), .best(rest_prio));

  // named events
  logic rd_ack, eoi_wr, ack_ok, raise_take, raise_pulse, eoi_pulse;
  logic [PW-1:0] raise_pri;
  assign rd_ack      = reg_rd && (reg_addr == REG_ACK);
  assign eoi_wr      = reg_wr && (reg_addr == REG_EOI);
  assign ack_ok      = rd_ack && r_found && src_active[r_idx] && (r_prio > tpri_q);
  assign raise_pri   = prio_of(raise_idx);
  assign raise_take  = raise_vld && (raise_pri > tpri_q);
  assign raise_pulse = raise_take && (!r_found || raise_pri >= r_prio);
  assign eoi_pulse   = eoi_wr && r_found && (!rest_found || r_prio > rest_prio);

  assign act_clr_vld  = rd_ack && r_found && (!ack_ok || !src_level[r_idx]);
  assign pend_clr_vld = rd_ack && r_found && !src_level[r_idx];
  assign act_clr_idx  = r_idx;

  always_comb begin
    raised_nxt = raised_q;
    if (rd_ack && r_found) raised_nxt = raised_nxt & ~bit_of(r_idx);
    if (raise_take)        raised_nxt = raised_nxt | bit_of(raise_idx);
    serv_nxt = serv_q;
    if (ack_ok)            serv_nxt = serv_nxt | bit_of(r_idx);
    if (eoi_wr && s_found) serv_nxt = serv_nxt & ~bit_of(s_idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raised_q <= '0;
      serv_q   <= '0;
      tpri_q   <= '1;
      spur_q   <= '1;
    end else begin
      raised_q <= raised_nxt;
      serv_q   <= serv_nxt;
      if (reg_wr && reg_addr == REG_TASKPRI) tpri_q <= reg_wdata[PW-1:0];
      if (reg_wr && reg_addr == REG_SPUR)    spur_q <= reg_wdata[VEC_W-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      REG_TASKPRI: reg_rdata = 32'(tpri_q);
      REG_WHOAMI:  reg_rdata = 32'(CPU_ID);
      REG_ACK:     reg_rdata = ack_ok ? 32'(src_vec[r_idx*VEC_W +: VEC_W]) : 32'(spur_q);
      REG_SPUR:    reg_rdata = 32'(spur_q);
      default:     reg_rdata = 32'd0;
    endcase
  end

  iack_line u_line (
    .clk(clk), .rst_n(rst_n),
    .lower(rd_ack),
    .set(raise_pulse || eoi_pulse),
    .set_crit(raise_pulse ? crit_of(raise_idx) : crit_of(r_idx)),
    .irq_o(irq_o), .crit_o(crit_o));

  // R2
  raise_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raise_vld && raise_pri <= tpri_q && !rd_ack |=> raised_q == $past(raised_q));
  // R10
  tpri_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == REG_TASKPRI |=> tpri_q == $past(reg_wdata[PW-1:0]));
  // R7
  ack_serv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ok |=> $countones(serv_q) == $countones($past(serv_q | bit_of(r_idx))));
  // R9
  eoi_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr && s_found |=> $countones(serv_q) + 1 == $countones($past(serv_q)));
  // R8
  clr_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_clr_vld || pend_clr_vld) |-> rd_ack && r_found);
  // R6
  ack_remove_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack && r_found && !raise_vld |=> !raised_q[$past(r_idx)]);
endmodule

// File: tb/iack_arbiter_bench.sv
module iack_arbiter_bench;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic raise_vld = 0; logic [2:0] raise_idx = 0;
  logic [N*4-1:0] src_prio; logic [N*8-1:0] src_vec;
  logic [N-1:0] src_active, src_level; logic [N*4-1:0] src_route;
  logic crit_en = 0, reg_rd = 0, reg_wr = 0;
  logic [2:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata; logic irq_o, crit_o, act_clr_vld, pend_clr_vld;
  logic [2:0] act_clr_idx;

  int sp[N]; int sv[N]; bit sa[N]; bit sl[N]; bit sc[N];
  always_comb
    for (int i = 0; i < N; i++) begin
      src_prio[i*4 +: 4] = 4'(sp[i]);
      src_vec[i*8 +: 8]  = 8'(sv[i]);
      src_active[i] = sa[i];
      src_level[i]  = sl[i];
      src_route[i*4 +: 4] = {1'b0, sc[i], 2'b00};
    end

  iack_arbiter u_iack_arbiter (.*);

  // reference model
  bit mr[N]; bit ms[N]; int m_tpri = 15; int m_spur = 255;
  bit m_irq = 0; bit m_crit = 0;
  int n_cmp = 0, n_bad = 0, pend_act = -1;
  string last_tag = "R1";

  function automatic int mpick(bit s[N]);
    int b = -1;
    for (int i = N - 1; i >= 0; i--)
      if (s[i] && (b < 0 || sp[i] >= sp[b])) b = i;
    return b;
  endfunction

  function automatic bit mcrit(int i);
    return crit_en && sc[i];
  endfunction

  task automatic chk(string tag, int act, int exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic setline(bit c);
    if (c) m_crit = 1; else m_irq = 1;
  endtask

  task automatic cyc(bit rd, bit wr, int addr, int wd, bit rv, int ri, string tag);
    int w, s, rest, er; bit ok, eact, epend;
    @(negedge clk);
    chk(last_tag, int'(irq_o), int'(m_irq), "irq_o");
    chk(last_tag, int'(crit_o), int'(m_crit), "crit_o");
    if (pend_act >= 0) sa[pend_act] = 0;
    pend_act = -1;
    reg_rd = rd; reg_wr = wr; reg_addr = 3'(addr); reg_wdata = 32'(wd);
    raise_vld = rv; raise_idx = 3'(ri);
    if (rv) sa[ri] = 1;
    #1;
    w = mpick(mr);
    eact = 0; epend = 0; er = 0;
    if (rd) begin
      case (addr)
        0: er = m_tpri;
        1: er = 1;
        2: er = m_spur;
        4: er = m_spur;
        default: er = 0;
      endcase
      if (addr == 2) begin
        m_irq = 0; m_crit = 0;
        if (w >= 0) begin
          ok = sa[w] && sp[w] > m_tpri;
          if (ok) begin er = sv[w]; ms[w] = 1; end
          eact = !ok || !sl[w];
          epend = !sl[w];
          if (eact) pend_act = w;
          mr[w] = 0;
        end
      end
      chk(tag, int'(reg_rdata), er, "rdata");
    end
    chk(tag, int'(act_clr_vld), int'(eact), "act_clr_vld");
    chk(tag, int'(pend_clr_vld), int'(epend), "pend_clr_vld");
    if (eact) chk(tag, int'(act_clr_idx), w, "act_clr_idx");
    if (wr) begin
      if (addr == 0) m_tpri = wd & 15;
      if (addr == 4) m_spur = wd & 255;
      if (addr == 3) begin
        s = mpick(ms);
        if (s >= 0) ms[s] = 0;
        rest = mpick(ms);
        if (w >= 0 && (rest < 0 || sp[w] > sp[rest])) setline(mcrit(w));
      end
    end
    if (rv && sp[ri] > m_tpri) begin
      if (w < 0 || sp[ri] >= sp[w]) setline(mcrit(ri));
      mr[ri] = 1;
    end
    last_tag = tag;
  endtask

  task automatic rdr(int a, string t);  cyc(1, 0, a, 0, 0, 0, t); endtask
  task automatic wrr(int a, int d, string t); cyc(0, 1, a, d, 0, 0, t); endtask
  task automatic rai(int i, string t);  cyc(0, 0, 0, 0, 1, i, t); endtask
  task automatic idle(string t);        cyc(0, 0, 0, 0, 0, 0, t); endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      sv[i] = 16 + i; sa[i] = 0; sl[i] = 1; sc[i] = 0; mr[i] = 0; ms[i] = 0;
    end
    sp[0] = 3; sp[1] = 5; sp[2] = 5; sp[3] = 1; sp[4] = 7; sp[5] = 6; sp[6] = 8; sp[7] = 4;
    sl[7] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    rdr(0, "R1"); rdr(4, "R1"); idle("R1");
    // R11 identity and empty ack (R6)
    rdr(1, "R11"); wrr(1, 7, "R11"); rdr(1, "R11"); rdr(2, "R6"); rdr(3, "R11");
    // R10 task priority keeps the low 4 bits
    wrr(0, 32'hF3, "R10"); rdr(0, "R10"); wrr(0, 2, "R10");
    // R2 raise at or below task priority is dropped
    rai(3, "R2"); idle("R2"); rdr(2, "R2");
    // R3 / R5 raise, tie, lower raise
    rai(1, "R3"); idle("R3"); rai(2, "R5"); rai(0, "R3"); idle("R3");
    rdr(2, "R5"); idle("R6"); rdr(2, "R5"); idle("R6");
    // R9 EOI retire and conditional re-raise
    wrr(3, 0, "R9"); idle("R9"); wrr(3, 0, "R9"); idle("R9");
    rdr(2, "R9"); wrr(3, 0, "R9"); idle("R9");
    // R7 task priority raised after raise
    rai(4, "R7"); wrr(0, 9, "R7"); rdr(2, "R7"); idle("R7"); wrr(0, 2, "R7");
    // R7 inactive winner
    rai(5, "R7"); idle("R7"); sa[5] = 0; rdr(2, "R7"); idle("R7");
    // R8 edge-sensitive source
    rai(7, "R8"); idle("R8"); rdr(2, "R8"); idle("R8"); wrr(3, 0, "R8");
    // R4 critical routing
    crit_en = 1; sc[6] = 1;
    rai(6, "R4"); idle("R4"); rdr(2, "R4"); idle("R4"); wrr(3, 0, "R4"); idle("R4");
    // R11 spurious vector register
    wrr(4, 32'h1A5, "R11"); rdr(4, "R11"); rdr(2, "R11"); idle("R11");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule